// File: doc/BRIEF.md
# AT-Bus SRAM Expansion Window Decoder

This block holds the address decode and select logic for a 16-bit AT-bus memory expansion card. The card is built from byte-wide 512K×8 static RAMs. A bank is a pair of these chips: one holds the even (low) byte and one holds the odd (high) byte. The card carries between one and `NBANK` banks. Each bank answers in its own 1 MB window, chosen by the unlatched upper address nibble. The first window is set by a configuration input, and the following banks sit in the windows just above it.

The block has two timing paths. The 16-bit response goes out as early as possible, as a purely combinational function of the live upper address nibble. The bank selection that drives the chip enables passes through a latch. That latch is transparent while the address-latch strobe is high and freezes when the strobe falls, so the chip selects stay fixed for the rest of the bus cycle. The byte-lane enables come from the low address bit and the byte-high enable. The command strobes then gate the chip enables, the SRAM output and write enables, and the two byte-lane data transceivers. An idle card never drives the data bus.

All pins are plain, level-sensitive bus signals with no handshake. Active-low pins carry the suffix `_n`.

Top module: `isa_mem_window`

## Requirements
- R1: `memcs16_n_o` is low exactly when the live `la_i` satisfies `cfg_base_i <= la_i < cfg_base_i + N`, where N is the effective bank count. Windows do not wrap past 15. The output does not depend on the strobe or on the commands.
- R2: Bank n answers at `la_i == cfg_base_i + n`. Its low-byte chip enable is `sram_ce_n_o[2n]` and its high-byte chip enable is `sram_ce_n_o[2n+1]`, both active low. At most one bank is enabled at a time.
- R3: The bank selection feeding the chip enables follows `la_i` while `bale_i` is 1. It holds its last value while `bale_i` is 0.
- R4: The low lane is enabled when `sa_i[0]` is 0 and the high lane when `sbhe_n_i` is 0. An aligned word access (`sa_i[0]`=0, `sbhe_n_i`=0) enables both lanes. An odd byte access (`sa_i[0]`=1, `sbhe_n_i`=0) enables only the high lane.
- R5: `sram_addr_o` equals `sa_i[19:1]`. Bit 0 of `sa_i` is used only as the lane select.
- R6: `sram_oe_n_o` is low only while `memr_n_i` is 0 and the latched selection hits.
- R7: `sram_we_n_o` is low only while `memw_n_i` is 0, `memr_n_i` is 1 and the latched selection hits. A read strobe overrides a write strobe.
- R8: `xcvr_dir_o` is 1 (SRAM toward the bus) while `memr_n_i` is 0, and 0 otherwise.
- R9: A lane's transceiver enable is low only when that lane is enabled, a command is active and the latched selection hits.
- R10: With both `memr_n_i` and `memw_n_i` at 1, all chip enables, both output controls and both transceiver enables are high.
- R11: A `cfg_nbanks_i` of 0 gives no window at all. A value above `NBANK` acts as `NBANK`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| la_i | input | 4 | Unlatched upper address nibble (window number) |
| sa_i | input | 20 | Latched system address |
| sbhe_n_i | input | 1 | Byte-high enable, active low |
| bale_i | input | 1 | Address-latch strobe; the selection latch is transparent while high |
| memr_n_i | input | 1 | Memory read command, active low |
| memw_n_i | input | 1 | Memory write command, active low |
| cfg_base_i | input | 4 | Window number of bank 0 |
| cfg_nbanks_i | input | 3 | Number of installed banks |
| memcs16_n_o | output | 1 | Early 16-bit response, active low |
| sram_addr_o | output | 19 | Address to every SRAM |
| sram_ce_n_o | output | 8 | Chip enables, bit 2n low byte and 2n+1 high byte of bank n |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| sram_we_n_o | output | 1 | SRAM write enable, active low |
| xcvr_lo_en_n_o | output | 1 | Low-lane transceiver enable, active low |
| xcvr_hi_en_n_o | output | 1 | High-lane transceiver enable, active low |
| xcvr_dir_o | output | 1 | Transceiver direction, 1 = toward the bus |

## Verification
Every output responds in the same cycle, because the path holds no flip-flop, only gates and one level-sensitive latch. The bench changes inputs on the falling clock edge and samples 2 ns later, well before the next rising edge. The 16-bit response is checked while the strobe is still high, because it follows the live nibble. The chip enables and strobes are checked after the strobe has fallen and the nibble has been moved to another window. A result there can only come from the held selection.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;

  // Byte-lane request derived from the low address bit and byte-high enable.
  typedef struct packed {
    logic hi;
    logic lo;
  } lane_t;

  // Command phase seen on the two active-low strobes; read wins over write.
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  function automatic cmd_e cmd_decode(input logic rd_n, input logic wr_n);
    if (!rd_n)      return CMD_READ;
    else if (!wr_n) return CMD_WRITE;
    else            return CMD_IDLE;
  endfunction

  function automatic lane_t lane_decode(input logic a0, input logic bhe_n);
    lane_t l;
    l.lo = ~a0;
    l.hi = ~bhe_n;
    return l;
  endfunction

endpackage

// File: rtl/win_decode.sv
module win_decode #(
  parameter int LA_W   = 4,
  parameter int NBANK  = 4,
  parameter int NB_W   = 3,
  parameter int BANK_W = 2
) (
  input  logic [LA_W-1:0]   la,
  input  logic [LA_W-1:0]   base,
  input  logic [NB_W-1:0]   nbanks,
  output logic              hit,
  output logic [BANK_W-1:0] bank
);
  localparam int CMP_W = (LA_W > NB_W) ? LA_W : NB_W;

  logic [LA_W:0]      diff;
  logic [NB_W-1:0]    nb_eff;
  logic [CMP_W-1:0]   off_ext;
  logic [CMP_W-1:0]   nb_ext;

  always_comb begin
    // Extra top bit catches la below base: no wrap-around windows.
    diff    = {1'b0, la} - {1'b0, base};
    nb_eff  = (nbanks > NB_W'(NBANK)) ? NB_W'(NBANK) : nbanks;
    off_ext = CMP_W'(diff[LA_W-1:0]);
    nb_ext  = CMP_W'(nb_eff);
    hit     = !diff[LA_W] && (off_ext < nb_ext);
    bank    = diff[BANK_W-1:0];
  end

  // R1/R11: a hit always names a bank within the effective count
  always_comb begin
    if (hit) begin
      a_r11_bank_in_range: assert (CMP_W'(bank) < nb_ext && nb_ext <= CMP_W'(NBANK));
    end
  end

endmodule

// File: rtl/sel_latch.sv
module sel_latch #(
  parameter int W = 3
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Level-sensitive hold: open while the address strobe is high.
  always_latch begin
    if (en) q = d;
  end
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import isa_win_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input  logic               sel_hit,
  input  logic [BANK_W-1:0]  sel_bank,
  input  logic               a0,
  input  logic               bhe_n,
  input  logic               rd_n,
  input  logic               wr_n,
  output logic [2*NBANK-1:0] ce_n,
  output logic               oe_n,
  output logic               we_n,
  output logic               lo_en_n,
  output logic               hi_en_n,
  output logic               dir
);
  lane_t lanes;
  cmd_e  cmd;
  logic  active;

  always_comb begin
    lanes  = lane_decode(a0, bhe_n);
    cmd    = cmd_decode(rd_n, wr_n);
    active = sel_hit && (cmd != CMD_IDLE);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic mine;
    assign mine          = active && (sel_bank == BANK_W'(b));
    assign ce_n[2*b]     = ~(mine && lanes.lo);
    assign ce_n[2*b + 1] = ~(mine && lanes.hi);
  end

  assign oe_n    = ~(sel_hit && cmd == CMD_READ);
  assign we_n    = ~(sel_hit && cmd == CMD_WRITE);
  assign dir     = (cmd == CMD_READ);
  assign lo_en_n = ~(active && lanes.lo);
  assign hi_en_n = ~(active && lanes.hi);

  always_comb begin
    // R10: idle strobes leave every enable released
    if (rd_n && wr_n) begin
      a_r10_idle_quiet: assert (&ce_n && oe_n && we_n && lo_en_n && hi_en_n);
    end
    // R7: the SRAM is never asked to read and write at once
    a_r7_no_rw_clash: assert (oe_n || we_n);
    // R2: at most one bank pair enabled
    a_r2_one_bank: assert ($countones(~ce_n) <= 2);
    // R9: a lane transceiver only opens alongside a chip of that lane
    if (!lo_en_n || !hi_en_n) begin
      a_r9_xcvr_with_chip: assert (!(&ce_n));
    end
  end

endmodule

// File: rtl/isa_mem_window.sv
module isa_mem_window #(
  parameter int LA_W    = 4,
  parameter int SA_W    = 20,
  parameter int NBANK   = 4,
  localparam int NB_W   = $clog2(NBANK + 1),
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CE_W   = 2 * NBANK
) (
  input  logic [LA_W-1:0] la_i,
  input  logic [SA_W-1:0] sa_i,
  input  logic            sbhe_n_i,
  input  logic            bale_i,
  input  logic            memr_n_i,
  input  logic            memw_n_i,
  input  logic [LA_W-1:0] cfg_base_i,
  input  logic [NB_W-1:0] cfg_nbanks_i,
  output logic            memcs16_n_o,
  output logic [SA_W-2:0] sram_addr_o,
  output logic [CE_W-1:0] sram_ce_n_o,
  output logic            sram_oe_n_o,
  output logic            sram_we_n_o,
  output logic            xcvr_lo_en_n_o,
  output logic            xcvr_hi_en_n_o,
  output logic            xcvr_dir_o
);
  logic              live_hit;
  logic [BANK_W-1:0] live_bank;
  logic              held_hit;
  logic [BANK_W-1:0] held_bank;

  // Early path: live nibble straight to the 16-bit response.
  win_decode #(
    .LA_W(LA_W), .NBANK(NBANK), .NB_W(NB_W), .BANK_W(BANK_W)
  ) u_dec (
    .la(la_i), .base(cfg_base_i), .nbanks(cfg_nbanks_i),
    .hit(live_hit), .bank(live_bank)
  );

  assign memcs16_n_o = ~live_hit;

  // Select path: decode held across the command phase.
  sel_latch #(.W(BANK_W + 1)) u_lat (
    .en(bale_i),
    .d ({live_hit, live_bank}),
    .q ({held_hit, held_bank})
  );

  assign sram_addr_o = sa_i[SA_W-1:1];

  lane_ctrl #(.NBANK(NBANK), .BANK_W(BANK_W)) u_lane (
    .sel_hit (held_hit),
    .sel_bank(held_bank),
    .a0      (sa_i[0]),
    .bhe_n   (sbhe_n_i),
    .rd_n    (memr_n_i),
    .wr_n    (memw_n_i),
    .ce_n    (sram_ce_n_o),
    .oe_n    (sram_oe_n_o),
    .we_n    (sram_we_n_o),
    .lo_en_n (xcvr_lo_en_n_o),
    .hi_en_n (xcvr_hi_en_n_o),
    .dir     (xcvr_dir_o)
  );

  // R3: while transparent, the held selection equals the live decode
  always_comb begin
    if (bale_i) begin
      a_r3_latch_follows: assert (held_hit == live_hit);
    end
  end

endmodule

// File: tb/isa_mem_window_tb.sv
module isa_mem_window_tb;

  logic        clk = 1'b0;
  logic [3:0]  la;
  logic [19:0] sa;
  logic        sbhe_n, bale, memr_n, memw_n;
  logic [3:0]  cfg_base;
  logic [2:0]  cfg_nb;
  logic        cs16_n, oe_n, we_n, lo_n, hi_n, dir;
  logic [18:0] addr;
  logic [7:0]  ce_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  isa_mem_window u_dut (
    .la_i(la), .sa_i(sa), .sbhe_n_i(sbhe_n), .bale_i(bale),
    .memr_n_i(memr_n), .memw_n_i(memw_n),
    .cfg_base_i(cfg_base), .cfg_nbanks_i(cfg_nb),
    .memcs16_n_o(cs16_n), .sram_addr_o(addr), .sram_ce_n_o(ce_n),
    .sram_oe_n_o(oe_n), .sram_we_n_o(we_n),
    .xcvr_lo_en_n_o(lo_n), .xcvr_hi_en_n_o(hi_n), .xcvr_dir_o(dir)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // cmd: 0 idle, 1 read, 2 write. ce bit 2n = bank n low byte, 2n+1 high byte.
  typedef struct packed {
    logic [3:0] base;
    logic [2:0] nb;
    logic [3:0] la;
    logic       a0;
    logic       bhe_n;
    logic [1:0] cmd;
    logic       cs;
    logic [7:0] ce;
    logic       oe;
    logic       we;
    logic       lo;
    logic       hi;
    logic       dir;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{4'd1,  3'd4, 4'd1,  1'b0, 1'b0, 2'd1, 1'b0, 8'hFC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd1,  3'd4, 4'd4,  1'b0, 1'b1, 2'd2, 1'b0, 8'hBF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd1,  3'd4, 4'd5,  1'b0, 1'b0, 2'd1, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{4'd1,  3'd4, 4'd0,  1'b0, 1'b0, 2'd2, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{4'd1,  3'd4, 4'd2,  1'b1, 1'b0, 2'd1, 1'b0, 8'hF7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{4'd8,  3'd2, 4'd9,  1'b0, 1'b0, 2'd2, 1'b0, 8'hF3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd8,  3'd2, 4'd10, 1'b0, 1'b0, 2'd1, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{4'd14, 3'd4, 4'd15, 1'b0, 1'b1, 2'd1, 1'b0, 8'hFB, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd14, 3'd4, 4'd0,  1'b0, 1'b0, 2'd2, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{4'd1,  3'd0, 4'd1,  1'b0, 1'b0, 2'd1, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{4'd1,  3'd1, 4'd1,  1'b1, 1'b1, 2'd1, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{4'd1,  3'd4, 4'd3,  1'b0, 1'b0, 2'd0, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  initial begin : watchdog
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    la = 4'd0; sa = 20'h0; sbhe_n = 1'b1; bale = 1'b0;
    memr_n = 1'b1; memw_n = 1'b1; cfg_base = 4'd1; cfg_nb = 3'd4;

    // R10: idle state after power-up, no command
    @(negedge clk); #2;
    check("R10 idle ce", 32'(ce_n), 32'hFF);
    check("R10 idle oe/we/xcvr", {oe_n, we_n, lo_n, hi_n}, 4'hF);

    // Vector table: decode captured while strobe high, then nibble moved away.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_base = TBL[i].base; cfg_nb = TBL[i].nb;
      la = TBL[i].la; sa = {19'(i * 4099), TBL[i].a0}; sbhe_n = TBL[i].bhe_n;
      memr_n = 1'b1; memw_n = 1'b1; bale = 1'b1;
      #2;
      check($sformatf("R1/R11 vec%0d cs16", i), 32'(cs16_n), 32'(TBL[i].cs));
      check($sformatf("R5 vec%0d addr", i), 32'(addr), 32'(i * 4099));
      @(negedge clk);
      bale = 1'b0;
      #1;
      la = TBL[i].la ^ 4'h8;
      memr_n = (TBL[i].cmd != 2'd1);
      memw_n = (TBL[i].cmd != 2'd2);
      #2;
      check($sformatf("R2/R3/R4 vec%0d ce", i), 32'(ce_n), 32'(TBL[i].ce));
      check($sformatf("R6 vec%0d oe", i), 32'(oe_n), 32'(TBL[i].oe));
      check($sformatf("R7 vec%0d we", i), 32'(we_n), 32'(TBL[i].we));
      check($sformatf("R9 vec%0d xcvr", i), {lo_n, hi_n}, {TBL[i].lo, TBL[i].hi});
      check($sformatf("R8 vec%0d dir", i), 32'(dir), 32'(TBL[i].dir));
      @(negedge clk);
      memr_n = 1'b1; memw_n = 1'b1;
      #2;
      check($sformatf("R10 vec%0d release", i), {ce_n, oe_n, we_n, lo_n, hi_n}, 12'hFFF);
    end

    // R3: transparent latch follows a changing nibble while strobe high
    @(negedge clk);
    cfg_base = 4'd1; cfg_nb = 3'd4; sa = 20'h0; sbhe_n = 1'b0;
    la = 4'd2; bale = 1'b1; memr_n = 1'b0;
    #2;
    check("R3 transparent hit bank1", 32'(ce_n), 32'hF3);
    la = 4'd9;
    #2;
    check("R3 transparent follows miss", 32'(ce_n), 32'hFF);
    check("R1 live cs16 miss", 32'(cs16_n), 32'h1);
    la = 4'd3;
    #1;
    bale = 1'b0;
    #1;
    la = 4'd0;
    #2;
    check("R3 hold bank2 after strobe falls", 32'(ce_n), 32'hCF);
    check("R1 cs16 follows live nibble", 32'(cs16_n), 32'h1);

    // R7: read and write strobes together, read wins
    memw_n = 1'b0;
    #2;
    check("R7 read overrides write we", 32'(we_n), 32'h1);
    check("R6 read with both strobes oe", 32'(oe_n), 32'h0);
    memr_n = 1'b1; memw_n = 1'b1;

    // R11: oversized count clamps to four banks
    @(negedge clk);
    cfg_nb = 3'd7; la = 4'd5; bale = 1'b1;
    #2;
    check("R11 clamp miss at base+4", 32'(cs16_n), 32'h1);
    la = 4'd4;
    #2;
    check("R11 clamp hit at base+3", 32'(cs16_n), 32'h0);
    bale = 1'b0;
    #1;
    memw_n = 1'b0; sbhe_n = 1'b0; sa = 20'h1;
    #2;
    check("R4 odd byte only high lane bank3", 32'(ce_n), 32'h7F);
    check("R4 odd byte xcvr", {lo_n, hi_n}, 2'b10);
    memw_n = 1'b1;

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule